// File: doc/BRIEF.md
# Speculative Windowed-Carry Adder

This block adds two unsigned operands and returns a fast speculative sum first and the exact sum later. In the speculative path, the carry into each bit position depends only on a bounded window of the K bit pairs just below it. The carry entering that window is taken as zero. Because of this, the speculative path has a logic depth set by K rather than by the operand width. When no carry has to travel further than K positions, the speculative result is already the correct one.

An exact adder sits beside the speculative path and checks it. The exact result is registered one cycle after the speculative one, which gives it the full worst-case delay to settle. In that later cycle the block compares the two results and presents the exact sum and carry-out. It also raises a mismatch flag when the speculative value was wrong. A consumer acts on the speculative sum at once and, on a mismatch, replaces it with the exact value. Operations may be issued back to back, one per cycle.

Top module: `spec_window_adder`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `spec_valid`, `chk_valid` and `mismatch` are 0.
- R2: An operation issued with `in_valid` high at a clock edge appears on `spec_sum` / `spec_cout` after that edge, with `spec_valid` high for exactly that one cycle. In the speculative result, the carry into bit j is the generate/propagate fold of operand bits j-1 down to max(0, j-K), with zero carry entering the window. Sum bit j is a[j]^b[j]^carry(j).
- R3: Bits 0 through K of `spec_sum` always equal the same bits of the true sum, because their windows reach bit 0.
- R4: `spec_cout` is the windowed carry into bit position W, formed from bits W-K through W-1 only.
- R5: One cycle after `spec_valid`, `exact_sum` and `exact_cout` hold the full-width sum {cout, sum} = a + b of the same operation, and `chk_valid` is high for exactly that cycle.
- R6: In the `chk_valid` cycle, `mismatch` is 1 exactly when some carry chain is longer than K. That is the case when, for some j in K+1..W, bits j-K..j-1 all propagate (a^b = 1) and the true carry into bit j-K is 1. Equivalently, {spec_cout, spec_sum} differs from {exact_cout, exact_sum}.
- R7: A difference in the carry-out alone, with equal sum bits, also sets `mismatch`.
- R8: When `in_valid` is low, the speculative outputs keep their last value. `mismatch` is 0 in every cycle where `chk_valid` is 0.
- R9: Issuing operations back to back gives correct results for both cycles. The check of operation n and the speculative output of operation n+1 are presented in the same cycle without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the operands |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| spec_valid | output | 1 | Speculative result valid pulse |
| spec_sum | output | W | Speculative sum |
| spec_cout | output | 1 | Speculative carry-out |
| chk_valid | output | 1 | Check result valid pulse |
| exact_sum | output | W | Exact sum for recovery |
| exact_cout | output | 1 | Exact carry-out |
| mismatch | output | 1 | Speculative result was wrong |

## Verification
The check of one operation and the speculative result of the next operation land in the same cycle whenever issues come back to back. The bench provokes this with unbroken runs of random operands and with a stride-incrementing address stream. In each such cycle it compares both output groups at once against separately computed models. Long propagate runs are injected on purpose so that mismatches occur in overlapping cycles. One directed pattern yields a carry-out-only error. The expected mismatch is judged from an independent count of carry-chain length, not from comparing sums.

// File: rtl/wcadd_pkg.sv
package wcadd_pkg;

    localparam int DEF_WIDTH  = 32;
    localparam int DEF_WINDOW = 8;

    // per-bit carry generate / propagate pair
    typedef struct packed {
        logic g;
        logic p;
    } pg_t;

    localparam pg_t PG_IDENTITY = '{g: 1'b0, p: 1'b1};

    // fold a higher span onto a lower span
    function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    function automatic pg_t pg_make(input logic a, input logic b);
        pg_t r;
        r.g = a & b;
        r.p = a ^ b;
        return r;
    endfunction

endpackage

// File: rtl/wcadd_pg_gen.sv
module wcadd_pg_gen
    import wcadd_pkg::*;
#(
    parameter int W = DEF_WIDTH
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output pg_t  [W-1:0] pg_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pg_o[i] = pg_make(a_i[i], b_i[i]);
    end
endmodule

// File: rtl/wcadd_window_carry.sv
module wcadd_window_carry
    import wcadd_pkg::*;
#(
    parameter int W = DEF_WIDTH,
    parameter int K = DEF_WINDOW
) (
    input  pg_t  [W-1:0] pg_i,
    output logic [W:0]   carry_o
);
    localparam int KE = (K < 1) ? 1 : ((K > W) ? W : K);

    assign carry_o[0] = 1'b0;

    // R2: carry into bit j folds only bits j-1 .. max(0, j-K)
    for (genvar j = 1; j <= W; j++) begin : g_carry
        localparam int LO = (j > KE) ? (j - KE) : 0;
        pg_t  acc;
        logic cj;
        always_comb begin
            acc = PG_IDENTITY;
            for (int b = LO; b < j; b++) begin
                acc = pg_merge(pg_i[b], acc);
            end
            cj = acc.g;
        end
        assign carry_o[j] = cj;
    end
endmodule

// File: rtl/wcadd_exact.sv
module wcadd_exact #(
    parameter int W = wcadd_pkg::DEF_WIDTH
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] full;
    assign full   = {1'b0, a_i} + {1'b0, b_i};
    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
endmodule

// File: rtl/wcadd_compare.sv
module wcadd_compare #(
    parameter int W = wcadd_pkg::DEF_WIDTH
) (
    input  logic [W-1:0] spec_sum_i,
    input  logic         spec_cout_i,
    input  logic [W-1:0] exact_sum_i,
    input  logic         exact_cout_i,
    output logic         differ_o
);
    // R7: carry-out is part of the compared word
    assign differ_o = ({spec_cout_i, spec_sum_i} != {exact_cout_i, exact_sum_i});
endmodule

// File: rtl/spec_window_adder.sv
module spec_window_adder
    import wcadd_pkg::*;
#(
    parameter int W = DEF_WIDTH,
    parameter int K = DEF_WINDOW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         spec_valid,
    output logic [W-1:0] spec_sum,
    output logic         spec_cout,
    output logic         chk_valid,
    output logic [W-1:0] exact_sum,
    output logic         exact_cout,
    output logic         mismatch
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] sum;
        logic         cout;
    } spec_stage_t;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] sum;
        logic         cout;
        logic         miss;
    } check_stage_t;

    pg_t [W-1:0] pg;
    logic [W:0]  wcarry;
    logic [W-1:0] spec_sum_c;
    logic [W-1:0] exact_sum_c;
    logic         exact_cout_c;
    logic         differ_c;

    spec_stage_t  s1_q;
    check_stage_t s2_q;

    wcadd_pg_gen #(.W(W)) u_pg (
        .a_i  (op_a),
        .b_i  (op_b),
        .pg_o (pg)
    );

    wcadd_window_carry #(.W(W), .K(K)) u_win (
        .pg_i    (pg),
        .carry_o (wcarry)
    );

    for (genvar i = 0; i < W; i++) begin : g_sum
        assign spec_sum_c[i] = pg[i].p ^ wcarry[i];
    end

    // stage 1: speculative result (R2, R4, R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= in_valid;
            if (in_valid) begin
                s1_q.a    <= op_a;
                s1_q.b    <= op_b;
                s1_q.sum  <= spec_sum_c;
                s1_q.cout <= wcarry[W];
            end
        end
    end

    // exact adder works from the held operands over a full cycle
    wcadd_exact #(.W(W)) u_exact (
        .a_i    (s1_q.a),
        .b_i    (s1_q.b),
        .sum_o  (exact_sum_c),
        .cout_o (exact_cout_c)
    );

    wcadd_compare #(.W(W)) u_cmp (
        .spec_sum_i   (s1_q.sum),
        .spec_cout_i  (s1_q.cout),
        .exact_sum_i  (exact_sum_c),
        .exact_cout_i (exact_cout_c),
        .differ_o     (differ_c)
    );

    // stage 2: exact result and verdict (R5, R6, R9)
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.vld  <= s1_q.vld;
            s2_q.miss <= s1_q.vld & differ_c;
            if (s1_q.vld) begin
                s2_q.sum  <= exact_sum_c;
                s2_q.cout <= exact_cout_c;
            end
        end
    end

    assign spec_valid = s1_q.vld;
    assign spec_sum   = s1_q.sum;
    assign spec_cout  = s1_q.cout;
    assign chk_valid  = s2_q.vld;
    assign exact_sum  = s2_q.sum;
    assign exact_cout = s2_q.cout;
    assign mismatch   = s2_q.miss;
endmodule

// File: rtl/wcadd_checker.sv
module wcadd_checker #(
    parameter int W = wcadd_pkg::DEF_WIDTH,
    parameter int K = wcadd_pkg::DEF_WINDOW
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         spec_valid,
    input logic [W-1:0] spec_sum,
    input logic         spec_cout,
    input logic         chk_valid,
    input logic [W-1:0] exact_sum,
    input logic         exact_cout,
    input logic         mismatch
);
    localparam int KE = (K < 1) ? 1 : ((K >= W) ? W - 1 : K);

    AST_SPEC_PULSE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> spec_valid);                                              // R2

    AST_LOW_BITS_EXACT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (spec_sum[KE:0] == ($past(op_a[KE:0]) + $past(op_b[KE:0])))); // R3

    AST_CHECK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        spec_valid |=> chk_valid);                                             // R5

    AST_NO_CHECK_WITHOUT_SPEC: assert property (@(posedge clk) disable iff (rst)
        !spec_valid |=> !chk_valid);                                           // R5

    AST_EXACT_VALUE: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> ({exact_cout, exact_sum} ==
                       ({1'b0, $past(op_a, 2)} + {1'b0, $past(op_b, 2)})));    // R5

    AST_VERDICT: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> (mismatch == ($past({spec_cout, spec_sum}) != {exact_cout, exact_sum}))); // R6

    AST_QUIET_MISS: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> chk_valid);                                               // R8

    AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> ($stable(spec_sum) && $stable(spec_cout))); // R8
endmodule

bind spec_window_adder wcadd_checker #(.W(W), .K(K)) u_wcadd_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .spec_valid (spec_valid),
    .spec_sum   (spec_sum),
    .spec_cout  (spec_cout),
    .chk_valid  (chk_valid),
    .exact_sum  (exact_sum),
    .exact_cout (exact_cout),
    .mismatch   (mismatch)
);

// File: tb/tb_spec_window_adder.sv
module tb_spec_window_adder;
    localparam int W      = 32;
    localparam int K      = 8;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         spec_valid, spec_cout, chk_valid, exact_cout, mismatch;
    logic [W-1:0] spec_sum, exact_sum;

    int checks = 0;
    int failures = 0;
    int long_seen = 0;

    always #(CLK_NS/2) clk = ~clk;

    spec_window_adder #(.W(W), .K(K)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .spec_valid(spec_valid), .spec_sum(spec_sum), .spec_cout(spec_cout),
        .chk_valid(chk_valid), .exact_sum(exact_sum), .exact_cout(exact_cout),
        .mismatch(mismatch)
    );

    // windowed model straight from R2 / R4
    function automatic logic [W:0] spec_model(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] r;
        for (int j = 0; j <= W; j++) begin
            logic c = 1'b0;
            int lo = (j > K) ? j - K : 0;
            for (int i = lo; i < j; i++) c = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
            if (j < W) r[j] = a[j] ^ b[j] ^ c;
            else       r[W] = c;
        end
        return r;
    endfunction

    function automatic logic [W:0] exact_model(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    // R6: chain longer than K judged from propagate runs and true carries
    function automatic logic long_chain(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] t;
        t[0] = 1'b0;
        for (int i = 0; i < W; i++) t[i+1] = (a[i] & b[i]) | ((a[i] ^ b[i]) & t[i]);
        for (int j = K + 1; j <= W; j++) begin
            logic run = 1'b1;
            for (int i = j - K; i < j; i++) run = run & (a[i] ^ b[i]);
            if (run && t[j-K]) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    logic         h1_v = 1'b0, h2_v = 1'b0, have_last = 1'b0;
    logic [W-1:0] h1_a, h1_b, h2_a, h2_b;
    logic [W:0]   last_spec;

    // one cycle: check outputs for earlier issues, then drive the next
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] sm, em, got;
        @(negedge clk);
        check(spec_valid == h1_v, "R2 spec_valid", {{W{1'b0}}, spec_valid}, {{W{1'b0}}, h1_v});
        got = {spec_cout, spec_sum};
        if (h1_v) begin
            sm = spec_model(h1_a, h1_b);
            em = exact_model(h1_a, h1_b);
            check(got == sm, h2_v ? "R9 spec during check" : "R2 spec sum", got, sm);
            check(got[K:0] == em[K:0], "R3 low bits", {{(W-K){1'b0}}, got[K:0]}, {{(W-K){1'b0}}, em[K:0]});
            check(got[W] == sm[W], "R4 spec cout", {{W{1'b0}}, got[W]}, {{W{1'b0}}, sm[W]});
        end else if (have_last) begin
            check(got == last_spec, "R8 hold", got, last_spec);
        end
        check(chk_valid == h2_v, "R5 chk_valid", {{W{1'b0}}, chk_valid}, {{W{1'b0}}, h2_v});
        if (h2_v) begin
            logic exp_m;
            em = exact_model(h2_a, h2_b);
            sm = spec_model(h2_a, h2_b);
            exp_m = long_chain(h2_a, h2_b);
            if (exp_m) long_seen++;
            check({exact_cout, exact_sum} == em, "R5 exact", {exact_cout, exact_sum}, em);
            check(mismatch == exp_m,
                  (sm[W-1:0] == em[W-1:0] && sm[W] != em[W]) ? "R7 cout-only mismatch" :
                  (h1_v ? "R9 mismatch overlap" : "R6 mismatch"),
                  {{W{1'b0}}, mismatch}, {{W{1'b0}}, exp_m});
        end else begin
            check(mismatch == 1'b0, "R8 idle mismatch", {{W{1'b0}}, mismatch}, '0);
        end
        if (h1_v) begin
            last_spec = spec_model(h1_a, h1_b);
            have_last = 1'b1;
        end
        h2_v = h1_v; h2_a = h1_a; h2_b = h1_b;
        h1_v = v;    h1_a = a;    h1_b = b;
        in_valid = v; op_a = a; op_b = b;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check(!spec_valid && !chk_valid && !mismatch, "R1 reset", {{W{1'b0}}, mismatch}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!spec_valid && !chk_valid && !mismatch, "R1 after reset", {{W{1'b0}}, spec_valid}, '0);

        // directed corners
        step(1'b1, 32'hFF80_0000, 32'h0080_0000);   // carry-out-only error (R7)
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        step(1'b1, 32'hFFFF_FFFF, 32'h0000_0001);   // full-length chain
        step(1'b1, 32'h0000_00FF, 32'h0000_0001);   // chain ends inside low window
        step(1'b1, 32'h0000_01FF, 32'h0000_0001);   // chain of 9 into bit 9
        step(1'b1, 32'h0000_00FF, 32'h0000_0000);   // no carry
        step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // all generate
        step(1'b0, '0, '0);

        // random operands with gaps and injected long propagate runs
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] a = $urandom();
            logic [W-1:0] b = $urandom();
            if (($urandom() % 3) == 0) begin
                int pos = $urandom() % (W - K);
                logic [W-1:0] run = ((W'(1) << (K + 1)) - 1) << pos;
                b = (b & ~run) | (~a & run);
                b[pos] = a[pos] | ($urandom() % 2 == 0);
            end
            step(($urandom() % 4) != 0, a, b);
        end

        // stride-incrementing addresses, back to back
        begin
            logic [W-1:0] addr = 32'h7FFF_F000;
            for (int n = 0; n < 1500; n++) begin
                logic [W-1:0] stride = (n < 750) ? 32'h0000_0040 : 32'h0000_0008;
                step(1'b1, addr, stride);
                addr = addr + stride;
            end
        end
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        check(long_seen > 0, "R6 long chains provoked", W'(long_seen), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=done", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule